// File: doc/BRIEF.md
# Two-Clock Processor Bus Master

This block is the external memory bus interface of a small 8-bit processor. The core hands it one access at a time: a 16-bit byte address, a direction bit and, for a store, a data byte. The block then runs a bus cycle of exactly two clocks on a 16-bit address bus and an 8-bit data bus. It uses an active-low read strobe, an active-low write strobe and an output-enable that controls the tristate driver of the data lines.

In the first clock the address is presented and both strobes stay high. In the second clock one strobe is low. On a store, the byte is driven from the same rising edge that lowers the write strobe. On a load, the data lines are sampled on the falling clock edge in the middle of the second clock. The sampled byte is returned to the core with a one-clock completion pulse. While an access is in flight the block reports busy and ignores any new request. After a store the data stays driven for one extra clock, so a static memory that latches on the rising strobe sees stable data.

Top module: `cpu_bus_master`

## Requirements
- R1: While reset is high and after it is released with no request, bus_rd_n and bus_wr_n are 1, bus_dout_en, busy and done are 0.
- R2: A request seen with busy low at a rising edge starts an access. From that edge, bus_addr equals the request address and busy is 1 for exactly two clocks, then returns to 0.
- R3: On a read, bus_rd_n is 0 for exactly the second clock of the access and 1 otherwise. bus_wr_n stays 1 throughout.
- R4: On a read, rd_data takes the value bus_din held at the falling clock edge in the middle of the second clock. It changes only at the end of a read access and holds until the next read completes.
- R5: On a write, for exactly the second clock, bus_wr_n is 0, bus_dout_en is 1 and bus_dout equals the request data. bus_rd_n stays 1.
- R6: After a write, bus_dout_en stays 1 and bus_dout unchanged for the clock after bus_wr_n returns high. bus_dout_en is 0 in the clock after that.
- R7: Requests are ignored while busy is 1. A change of request address or direction during an access does not alter bus_addr or the strobes, and no further access follows unless the request is still present after busy falls.
- R8: done is a one-clock pulse in the clock following the second clock of every access, read or write.
- R9: bus_dout_en is 0 during a read access and whenever no write or write hold is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge sequences, the falling edge samples read data |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of the access |
| req_wdata | input | 8 | Byte to store on a write |
| busy | output | 1 | Access in flight; requests ignored |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| bus_addr | output | 16 | Address bus |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 8 | Data bus output value |
| bus_dout_en | output | 1 | Data bus driver enable; 0 = high impedance |
| bus_din | input | 8 | Data bus input value |

## Verification
A sequencer stuck in or skipping a phase shows at the ports within one clock. It appears as a strobe low for zero or two clocks, busy of the wrong length, or a missing or doubled done pulse. A read sampled on the wrong edge returns the deliberately different value the bus model presents before the strobe settles or after the falling edge. That error is seen in rd_data in the clock after the access. A driver enable that drops early or lingers is caught at the rising write strobe or one clock later. A request wrongly accepted while busy moves bus_addr in the very next clock.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_STROBE = 2'd2
  } phase_t;
endpackage

// File: rtl/bmx_seq.sv
module bmx_seq
  import bmx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output phase_t            phase,
  output logic              accept,
  output logic              is_write,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              busy,
  output logic              done
);
  assign accept = (phase == PH_IDLE) && req_valid;
  assign busy   = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      is_write  <= 1'b0;
      lat_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (accept) begin
          phase     <= PH_ADDR;
          is_write  <= req_write;
          lat_wdata <= req_wdata;
        end
        PH_ADDR:   phase <= PH_STROBE;
        PH_STROBE: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  p_busy_rises_two_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);
  p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/bmx_pins.sv
module bmx_pins
  import bmx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic              accept,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr    <= '0;
      bus_rd_n    <= 1'b1;
      bus_wr_n    <= 1'b1;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
    end else begin
      if (accept) bus_addr <= req_addr;
      case (phase)
        PH_ADDR: begin
          bus_rd_n <= is_write;
          bus_wr_n <= !is_write;
          if (is_write) begin
            bus_dout    <= lat_wdata;
            bus_dout_en <= 1'b1;
          end
        end
        PH_STROBE: begin
          bus_rd_n <= 1'b1;
          bus_wr_n <= 1'b1;
        end
        default: bus_dout_en <= 1'b0;
      endcase
    end
  end

  p_strobes_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));
  p_rd_one_clock_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd_n) |=> $rose(bus_rd_n));
  p_wr_drives_r5: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_dout_en);
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> (bus_dout_en && $stable(bus_dout)));
  p_rd_no_drive_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_dout_en);
  p_addr_held_r7: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase != PH_IDLE)) |-> $stable(bus_addr));
endmodule

// File: rtl/bmx_capture.sv
module bmx_capture
  import bmx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic              is_write,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] rd_data
);
  logic              sample_now;
  logic [DATA_W-1:0] mid_sample;

  assign sample_now = (phase == PH_STROBE) && !is_write;

  always_ff @(negedge clk) begin
    if (rst)             mid_sample <= '0;
    else if (sample_now) mid_sample <= bus_din;
  end

  always_ff @(posedge clk) begin
    if (rst)             rd_data <= '0;
    else if (sample_now) rd_data <= mid_sample;
  end

  p_rd_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(sample_now) |-> $stable(rd_data));
endmodule

// File: rtl/cpu_bus_master.sv
module cpu_bus_master
  import bmx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din
);
  phase_t            phase;
  logic              accept;
  logic              is_write;
  logic [DATA_W-1:0] lat_wdata;

  bmx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .phase(phase), .accept(accept),
    .is_write(is_write), .lat_wdata(lat_wdata), .busy(busy), .done(done)
  );

  bmx_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .phase(phase), .accept(accept),
    .is_write(is_write), .req_addr(req_addr), .lat_wdata(lat_wdata),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
  );

  bmx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .phase(phase), .is_write(is_write),
    .bus_din(bus_din), .rd_data(rd_data)
  );

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (bus_rd_n && bus_wr_n && !bus_dout_en && !busy && !done));
endmodule

// File: tb/test_cpu_bus_master.sv
`timescale 1ns/100ps
module test_cpu_bus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done, bus_rd_n, bus_wr_n, bus_dout_en;
  logic [7:0]  rd_data, bus_dout;
  logic [15:0] bus_addr;
  logic [7:0]  bus_din = '0;

  int errors = 0;
  int checks = 0;
  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];

  always #2.5 clk = ~clk;

  cpu_bus_master i_cpu_bus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  // Memory model: wrong value right after the strobe falls, the right value
  // before the mid-cycle falling edge, the complement after it.
  always @(negedge bus_rd_n) begin
    bus_din = 8'hC3;
    #1 bus_din = mem[bus_addr[7:0]];
  end
  always @(negedge clk) begin
    if (bus_rd_n === 1'b0) begin
      #0.5 bus_din = ~mem[bus_addr[7:0]];
    end
  end
  // Static memory latches on the rising write strobe (R6)
  always @(posedge bus_wr_n) begin
    if (!rst) begin
      chk(bus_dout_en === 1'b1, "R6 driver on at strobe rise", 32'(bus_dout_en), 1);
      mem[bus_addr[7:0]] = bus_dout;
    end
  end

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input bit hold_test);
    logic [7:0] exp_rd;
    exp_rd    = ref_mem[a[7:0]];
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk); #1;
    chk(busy === 1'b1, "R2 busy in first clock", 32'(busy), 1);
    chk(bus_addr === a, "R2 address driven", 32'(bus_addr), 32'(a));
    chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R3 strobes high in first clock",
        {bus_rd_n, bus_wr_n}, 3);
    chk(bus_dout_en === 1'b0, "R9 driver off in first clock", 32'(bus_dout_en), 0);
    if (hold_test) begin
      req_addr = ~a; req_write = !wr; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    @(negedge clk); #1;
    chk(busy === 1'b1, "R2 busy in second clock", 32'(busy), 1);
    chk(bus_addr === a, "R7 address held", 32'(bus_addr), 32'(a));
    if (wr) begin
      chk(bus_wr_n === 1'b0 && bus_rd_n === 1'b1, "R5 write strobe", {bus_rd_n, bus_wr_n}, 2);
      chk(bus_dout_en === 1'b1 && bus_dout === d, "R5 write data",
          {bus_dout_en, bus_dout}, {1'b1, d});
    end else begin
      chk(bus_rd_n === 1'b0 && bus_wr_n === 1'b1, "R3 read strobe", {bus_rd_n, bus_wr_n}, 1);
      chk(bus_dout_en === 1'b0, "R9 driver off during read", 32'(bus_dout_en), 0);
    end
    @(negedge clk); #1;
    if (hold_test) req_valid = 1'b0;
    chk(done === 1'b1, "R8 done pulse", 32'(done), 1);
    chk(busy === 1'b0, "R2 busy ends after two clocks", 32'(busy), 0);
    chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R3 strobes released",
        {bus_rd_n, bus_wr_n}, 3);
    chk(bus_addr === a, "R7 no accept while busy", 32'(bus_addr), 32'(a));
    if (wr) chk(bus_dout_en === 1'b1 && bus_dout === d, "R6 data held after strobe",
                {bus_dout_en, bus_dout}, {1'b1, d});
    else    chk(rd_data === exp_rd, "R4 read data sampled mid second clock",
                32'(rd_data), 32'(exp_rd));
    @(negedge clk); #1;
    chk(done === 1'b0, "R8 done one clock", 32'(done), 0);
    chk(bus_dout_en === 1'b0, "R6 R9 driver released", 32'(bus_dout_en), 0);
    chk(busy === 1'b0, "R7 no extra access", 32'(busy), 0);
    if (!wr) chk(rd_data === exp_rd, "R4 read data holds", 32'(rd_data), 32'(exp_rd));
    if (wr) ref_mem[a[7:0]] = d;
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] last_rd;
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_byte(i);
      ref_mem[i] = init_byte(i);
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, "R1 strobes in reset", {bus_rd_n, bus_wr_n}, 3);
    chk(bus_dout_en === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 idle in reset",
        {bus_dout_en, busy, done}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1 && bus_dout_en === 1'b0 && busy === 1'b0,
        "R1 idle after reset", {bus_rd_n, bus_wr_n, bus_dout_en, busy}, 4'b1100);

    access(1'b1, 16'h1234, 8'h5A, 1'b0);
    access(1'b0, 16'h1234, 8'h00, 1'b0);
    access(1'b0, 16'hFFFF, 8'h00, 1'b0);
    access(1'b0, 16'h0000, 8'h00, 1'b0);
    access(1'b1, 16'h8001, 8'hA5, 1'b1);
    access(1'b0, 16'h8001, 8'h00, 1'b1);
    last_rd = rd_data;
    access(1'b1, 16'h00FF, 8'hFF, 1'b0);
    chk(rd_data === last_rd, "R4 write leaves rd_data", 32'(rd_data), 32'(last_rd));

    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      access(1'($urandom), a, 8'($urandom), 1'($urandom_range(0, 7) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule